// File: doc/BRIEF.md
# Floating-Point Pipeline Sequencer with Operand Recirculation

This block is the control side of a three-stage floating-point pipeline that runs beside an integer core. The stages are conversion (CV), execute (EX) and write-back (WB), always visited in that order. The block takes decoded operations over a valid/ready handshake and tracks which operation sits in each stage. It drives a per-stage enable strobe for the fixed-latency datapath stubs outside it. It tells the integer core when it may move on, and it holds back any operation that touches a register an earlier operation has not yet written.

The block knows four operation classes, given on `op_class`: 0 is a register arithmetic operation, 1 is a load of an integer memory operand into a register, 2 is a store of a register to memory in integer format, and 3 is a register data move. An integer load travels the whole pipeline once to become extended precision, then re-enters CV and runs a second, arithmetic pass. A store is finished by CV alone and never reaches EX or WB. A move uses EX for a single cycle, so it can sit in the pipeline next to an arithmetic operation.

Each stage is a small state machine with three states. In STG_EMPTY the stage holds no operation. In STG_WORK it counts its latency down. In STG_HELD it has finished but the next stage cannot accept it yet. The transitions are: EMPTY to WORK on entry, WORK to HELD when the count is zero and the stage cannot leave, WORK or HELD to EMPTY on leaving, and WORK or HELD back to WORK when a new operation enters in the same cycle the old one leaves. The issue controller has two states. ISS_OPEN accepts new work. ISS_CONV is entered when an integer load is accepted and is left on the cycle that load recirculates into CV. Cycle numbers below count from H, the cycle in which `op_valid` and `op_ready` are both high. LCV, LEX and LWB are the stage latencies, and L = LCV+LEX+LWB.

Top module: `fpq_seq`

## Requirements
- R1: After reset `op_ready` is high, no register is marked busy, and `iu_release`, `st_done`, `wb_valid`, `cv_en`, `ex_en` and `wb_en` are all low.
- R2: With no stalls, an arithmetic operation (class 0) gives one `wb_valid` pulse in cycle H+L, carrying its destination on `wb_reg` and its tag on `wb_tag`.
- R3: With no stalls, a move (class 3) spends one cycle in EX and writes back in cycle H+LCV+1+LWB.
- R4: An integer load (class 1) makes two full passes and writes back once, in cycle H+2L. It does not read the `op_src` field.
- R5: A store (class 2) gives one `st_done` pulse with its tag in cycle H+LCV and never produces a `wb_valid` pulse.
- R6: `iu_release` pulses exactly once per operation, with that operation's tag on `iu_release_tag`. For classes 0, 1 and 3 the pulse comes in cycle H. For a store it comes in the `st_done` cycle.
- R7: Acceptance of a non-store marks its destination busy, and its write-back clears that mark. `op_ready` stays low while the source of a class 0, 2 or 3 operation is busy, or while the destination of a class 0, 1 or 3 operation is busy. A dependent operation is therefore accepted in the cycle after the write-back it waits on.
- R8: From the acceptance of an integer load until its recirculation into CV, `op_ready` is low. The recirculating load takes CV ahead of new work, and the next independent operation is accepted in cycle H+L+LCV+1.
- R9: Non-store operations write back in the order they were accepted. A store with no dependency may complete before an earlier arithmetic operation writes back.
- R10: An independent operation that follows another is accepted LCV+1 cycles after it, while the earlier one is still in EX.
- R11: `cv_en`, `ex_en` and `wb_en` are each high for exactly the cycles their stage spends counting an operation's latency, once per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The offered operation is accepted this cycle |
| op_class | input | 2 | 0 arithmetic, 1 integer load, 2 store, 3 move |
| op_src | input | 3 | Source FP register |
| op_dst | input | 3 | Destination FP register |
| op_tag | input | 4 | Identifier returned on completion |
| iu_release | output | 1 | The integer core may continue |
| iu_release_tag | output | 4 | Tag of the released operation |
| st_done | output | 1 | A store's converted data is ready this cycle |
| st_tag | output | 4 | Tag of the completing store |
| wb_valid | output | 1 | A register write-back happens this cycle |
| wb_reg | output | 3 | Register being written |
| wb_tag | output | 4 | Tag of the writing operation |
| cv_en | output | 1 | Conversion stub enable |
| ex_en | output | 1 | Execute stub enable |
| wb_en | output | 1 | Write-back stub enable |

## Verification
The assertions assume that an offered operation keeps `op_valid` high and its fields steady until it is accepted. They also assume that no integer load reaches write-back while an unrelated operation still occupies CV, which holds only because issue stays closed while a load is in its first pass. The bench offers every operation through one task that holds all fields until the handshake cycle, and it never withdraws an offer. It sweeps all classes over every source and destination pair with each operation run alone. It then runs short sequences aimed at the dependency, overlap, ordering and recirculation cases.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
    parameter int NREG  = 8;
    parameter int TAG_W = 4;
    localparam int REG_W = $clog2(NREG);

    typedef enum logic [1:0] {
        OPC_ARITH = 2'd0,
        OPC_LOAD  = 2'd1,
        OPC_STORE = 2'd2,
        OPC_MOVE  = 2'd3
    } opc_e;

    typedef struct packed {
        opc_e             cls;
        logic             second;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [TAG_W-1:0] tag;
    } op_t;
endpackage

// File: rtl/fpq_stage.sv
module fpq_stage
    import fpq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_i,
    input  op_t              info_i,
    input  logic [CNT_W-1:0] lat_i,
    input  logic             leave_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             work_o,
    output op_t              info_o
);
    typedef enum logic [1:0] {STG_EMPTY, STG_WORK, STG_HELD} stg_e;

    stg_e             st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    op_t              info_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= STG_EMPTY;
        else        st_q <= st_d;
    end

    // latency counter and carried operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            info_q <= '0;
        end else if (enter_i) begin
            cnt_q  <= lat_i - CNT_W'(1);
            info_q <= info_i;
        end else if (st_q == STG_WORK && cnt_q != '0) begin
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            STG_EMPTY: if (enter_i) st_d = STG_WORK;
            STG_WORK: begin
                if (cnt_q == '0) begin
                    if (leave_i) st_d = enter_i ? STG_WORK : STG_EMPTY;
                    else         st_d = STG_HELD;
                end
            end
            STG_HELD: if (leave_i) st_d = enter_i ? STG_WORK : STG_EMPTY;
            default:  st_d = STG_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (st_q != STG_EMPTY);
        work_o = (st_q == STG_WORK);
        done_o = (st_q == STG_HELD) || (st_q == STG_WORK && cnt_q == '0);
        info_o = info_q;
    end
endmodule

// File: rtl/fpq_scoreboard.sv
module fpq_scoreboard
    import fpq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_idx,
    input  logic             src_en,
    input  logic [REG_W-1:0] src_idx,
    input  logic             dst_en,
    input  logic [REG_W-1:0] dst_idx,
    output logic             conflict_o,
    output logic [NREG-1:0]  busy_o
);
    logic [NREG-1:0] busy_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                busy_q[g] <= 1'b0;
            else if (set_en && set_idx == REG_W'(g))
                busy_q[g] <= 1'b1;
            else if (clr_en && clr_idx == REG_W'(g))
                busy_q[g] <= 1'b0;
        end
    end

    always_comb begin
        conflict_o = (src_en && busy_q[src_idx]) || (dst_en && busy_q[dst_idx]);
        busy_o     = busy_q;
    end
endmodule

// File: rtl/fpq_seq.sv
module fpq_seq
    import fpq_pkg::*;
#(
    parameter int LAT_CV = 2,
    parameter int LAT_EX = 3,
    parameter int LAT_WB = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic [1:0]       op_class,
    input  logic [REG_W-1:0] op_src,
    input  logic [REG_W-1:0] op_dst,
    input  logic [TAG_W-1:0] op_tag,
    output logic             iu_release,
    output logic [TAG_W-1:0] iu_release_tag,
    output logic             st_done,
    output logic [TAG_W-1:0] st_tag,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_reg,
    output logic [TAG_W-1:0] wb_tag,
    output logic             cv_en,
    output logic             ex_en,
    output logic             wb_en
);
    localparam int LAT_M1  = (LAT_CV > LAT_EX) ? LAT_CV : LAT_EX;
    localparam int LAT_MAX = (LAT_M1 > LAT_WB) ? LAT_M1 : LAT_WB;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    typedef enum logic {ISS_OPEN, ISS_CONV} iss_e;

    iss_e iss_q, iss_d;

    op_t  new_op, recirc_op, cv_in, cv_info, ex_info, wb_info;
    logic cv_busy, cv_done, cv_work;
    logic ex_busy, ex_done, ex_work;
    logic wb_busy, wb_done, wb_work;
    logic fire, recirc, wb_first, wb_leave, wb_free;
    logic ex_leave, ex_free, cv_store, cv_leave, cv_enter;
    logic conflict, conv_pend;
    logic [CNT_W-1:0] ex_lat;
    logic [NREG-1:0]  sb_busy;

    // incoming operation
    always_comb begin
        new_op.cls    = opc_e'(op_class);
        new_op.second = 1'b0;
        new_op.src    = op_src;
        new_op.dst    = op_dst;
        new_op.tag    = op_tag;
        recirc_op        = wb_info;
        recirc_op.second = 1'b1;
    end

    // movement between stages, back to front
    always_comb begin
        wb_first = (wb_info.cls == OPC_LOAD) && !wb_info.second;
        recirc   = wb_done && wb_first && !cv_busy;
        wb_leave = wb_done && (!wb_first || recirc);
        wb_free  = !wb_busy || wb_leave;
        ex_leave = ex_done && wb_free;
        ex_free  = !ex_busy || ex_leave;
        cv_store = (cv_info.cls == OPC_STORE);
        cv_leave = cv_done && (cv_store || ex_free);
        ex_lat   = (cv_info.cls == OPC_MOVE) ? CNT_W'(1) : CNT_W'(LAT_EX);
    end

    // issue controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= ISS_OPEN;
        else        iss_q <= iss_d;
    end

    // issue controller: next state
    always_comb begin
        iss_d = iss_q;
        unique case (iss_q)
            ISS_OPEN: if (fire && new_op.cls == OPC_LOAD) iss_d = ISS_CONV;
            ISS_CONV: if (recirc) iss_d = ISS_OPEN;
            default:  iss_d = ISS_OPEN;
        endcase
    end

    // issue controller: outputs
    always_comb begin
        conv_pend = (iss_q == ISS_CONV);
        op_ready  = !conv_pend && !cv_busy && !conflict && !recirc;
        fire      = op_valid && op_ready;
        cv_enter  = fire || recirc;
        cv_in     = recirc ? recirc_op : new_op;
    end

    fpq_scoreboard u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (fire && new_op.cls != OPC_STORE),
        .set_idx    (op_dst),
        .clr_en     (wb_valid),
        .clr_idx    (wb_info.dst),
        .src_en     (new_op.cls != OPC_LOAD),
        .src_idx    (op_src),
        .dst_en     (new_op.cls != OPC_STORE),
        .dst_idx    (op_dst),
        .conflict_o (conflict),
        .busy_o     (sb_busy)
    );

    fpq_stage #(.CNT_W(CNT_W)) u_cv (
        .clk(clk), .rst_n(rst_n), .enter_i(cv_enter), .info_i(cv_in),
        .lat_i(CNT_W'(LAT_CV)), .leave_i(cv_leave), .busy_o(cv_busy),
        .done_o(cv_done), .work_o(cv_work), .info_o(cv_info)
    );

    fpq_stage #(.CNT_W(CNT_W)) u_ex (
        .clk(clk), .rst_n(rst_n), .enter_i(cv_leave && !cv_store), .info_i(cv_info),
        .lat_i(ex_lat), .leave_i(ex_leave), .busy_o(ex_busy),
        .done_o(ex_done), .work_o(ex_work), .info_o(ex_info)
    );

    fpq_stage #(.CNT_W(CNT_W)) u_wb (
        .clk(clk), .rst_n(rst_n), .enter_i(ex_leave), .info_i(ex_info),
        .lat_i(CNT_W'(LAT_WB)), .leave_i(wb_leave), .busy_o(wb_busy),
        .done_o(wb_done), .work_o(wb_work), .info_o(wb_info)
    );

    // completion and release outputs
    always_comb begin
        st_done        = cv_leave && cv_store;
        st_tag         = cv_info.tag;
        wb_valid       = wb_leave && !wb_first;
        wb_reg         = wb_info.dst;
        wb_tag         = wb_info.tag;
        iu_release     = (fire && new_op.cls != OPC_STORE) || st_done;
        iu_release_tag = st_done ? cv_info.tag : op_tag;
        cv_en          = cv_work;
        ex_en          = ex_work;
        wb_en          = wb_work;
    end
endmodule

// File: rtl/fpq_seq_chk.sv
module fpq_seq_chk
    import fpq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_ready,
    input logic [1:0]       op_class,
    input logic [REG_W-1:0] op_src,
    input logic [REG_W-1:0] op_dst,
    input logic             st_done,
    input logic             wb_valid,
    input logic [REG_W-1:0] wb_reg,
    input logic [NREG-1:0]  sb_busy,
    input logic             conv_pend,
    input logic             load_at_wb,
    input logic             cv_busy
);
    logic hs;
    assign hs = op_valid && op_ready;

    // R7
    sb_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs && op_class != 2'd2 |=> sb_busy[$past(op_dst)]);

    // R7
    src_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs && op_class != 2'd1 |-> !sb_busy[op_src]);

    // R7
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> sb_busy[wb_reg]);

    // R7
    wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !sb_busy[$past(wb_reg)]);

    // R8
    hold_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_pend |-> !op_ready);

    // R8
    recirc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_at_wb |-> !cv_busy);

    // R6
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && st_done));
endmodule

bind fpq_seq fpq_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_class   (op_class),
    .op_src     (op_src),
    .op_dst     (op_dst),
    .st_done    (st_done),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .sb_busy    (sb_busy),
    .conv_pend  (conv_pend),
    .load_at_wb (wb_done && wb_first),
    .cv_busy    (cv_busy)
);

// File: tb/fpq_seq_test.sv
module fpq_seq_test;
    localparam int LCV = 2;
    localparam int LEX = 3;
    localparam int LWB = 1;
    localparam int L   = LCV + LEX + LWB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_ready;
    logic [1:0] op_class = '0;
    logic [2:0] op_src = '0;
    logic [2:0] op_dst = '0;
    logic [3:0] op_tag = '0;
    logic       iu_release, st_done, wb_valid, cv_en, ex_en, wb_en;
    logic [3:0] iu_release_tag, st_tag, wb_tag;
    logic [2:0] wb_reg;

    int total = 0, bad = 0, cyc = 0;
    int last_hs, last_rel, last_wb, last_st, rel_n, wb_n, st_n;
    int rel_tag, wb_tg, wb_rg, st_tg, cv_cnt, ex_cnt, wb_cnt;
    int comp_log [0:63];
    int comp_n;

    fpq_seq #(.LAT_CV(LCV), .LAT_EX(LEX), .LAT_WB(LWB)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_class(op_class), .op_src(op_src), .op_dst(op_dst), .op_tag(op_tag),
        .iu_release(iu_release), .iu_release_tag(iu_release_tag),
        .st_done(st_done), .st_tag(st_tag), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .wb_tag(wb_tag), .cv_en(cv_en), .ex_en(ex_en), .wb_en(wb_en)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (op_valid && op_ready) last_hs = cyc;
            if (iu_release) begin rel_n++; last_rel = cyc; rel_tag = int'(iu_release_tag); end
            if (wb_valid) begin
                wb_n++; last_wb = cyc; wb_tg = int'(wb_tag); wb_rg = int'(wb_reg);
                comp_log[comp_n % 64] = int'(wb_tag); comp_n++;
            end
            if (st_done) begin
                st_n++; last_st = cyc; st_tg = int'(st_tag);
                comp_log[comp_n % 64] = int'(st_tag); comp_n++;
            end
            if (cv_en) cv_cnt++;
            if (ex_en) ex_cnt++;
            if (wb_en) wb_cnt++;
        end
    end

    task automatic clear_logs();
        last_hs = -1; last_rel = -1; last_wb = -1; last_st = -1;
        rel_n = 0; wb_n = 0; st_n = 0; comp_n = 0;
        cv_cnt = 0; ex_cnt = 0; wb_cnt = 0;
    endtask

    task automatic send(input int cls, input int src, input int dst, input int tag);
        @(posedge clk); #1;
        op_valid = 1'b1;
        op_class = 2'(cls); op_src = 3'(src); op_dst = 3'(dst); op_tag = 4'(tag);
        do @(negedge clk); while (!op_ready);
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int h1, h2, tag;
        clear_logs();
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(op_ready == 1'b1, "R1 ready", int'(op_ready), 1);
        chk({iu_release, st_done, wb_valid} == 3'b000, "R1 pulses", int'({iu_release, st_done, wb_valid}), 0);
        chk({cv_en, ex_en, wb_en} == 3'b000, "R1 strobes", int'({cv_en, ex_en, wb_en}), 0);

        // exhaustive single-operation sweep
        tag = 0;
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 8; s++) begin
                for (int d = 0; d < 8; d++) begin
                    int p, lex_op, comp;
                    clear_logs();
                    send(c, s, d, tag);
                    idle(2 * L + LCV + 4);
                    h1 = last_hs;
                    p = (c == 1) ? 2 : 1;
                    lex_op = (c == 3) ? 1 : LEX;
                    comp = (c == 2) ? h1 + LCV : h1 + p * (LCV + lex_op + LWB);
                    // R6 release
                    chk(rel_n == 1, "R6 release count", rel_n, 1);
                    chk(last_rel == ((c == 2) ? h1 + LCV : h1), "R6 release cycle", last_rel - h1,
                        (c == 2) ? LCV : 0);
                    chk(rel_tag == tag, "R6 release tag", rel_tag, tag);
                    if (c == 2) begin
                        // R5 store completes in conversion
                        chk(st_n == 1 && last_st == comp, "R5 store done cycle", last_st - h1, LCV);
                        chk(st_tg == tag, "R5 store tag", st_tg, tag);
                        chk(wb_n == 0, "R5 no write-back", wb_n, 0);
                        chk(cv_cnt == LCV && ex_cnt == 0 && wb_cnt == 0, "R11 store strobes",
                            cv_cnt * 100 + ex_cnt * 10 + wb_cnt, LCV * 100);
                    end else begin
                        // R2 arithmetic, R3 move, R4 load
                        chk(wb_n == 1 && last_wb == comp,
                            (c == 0) ? "R2 wb cycle" : (c == 3) ? "R3 wb cycle" : "R4 wb cycle",
                            last_wb - h1, comp - h1);
                        chk(wb_rg == d && wb_tg == tag, "R2 wb reg and tag", wb_rg * 16 + wb_tg, d * 16 + tag);
                        chk(st_n == 0, "R4 no store pulse", st_n, 0);
                        chk(cv_cnt == p * LCV && ex_cnt == p * lex_op && wb_cnt == p * LWB, "R11 strobes",
                            cv_cnt * 100 + ex_cnt * 10 + wb_cnt,
                            p * LCV * 100 + p * lex_op * 10 + p * LWB);
                    end
                    tag = (tag + 1) % 16;
                end
            end
        end

        // R10 overlap of a move behind an arithmetic op, R9 order
        clear_logs();
        send(0, 7, 0, 1); h1 = last_hs;
        send(3, 7, 1, 2); h2 = last_hs;
        idle(L + 8);
        chk(h2 == h1 + LCV + 1, "R10 overlap accept", h2 - h1, LCV + 1);
        chk(last_wb == h2 + LCV + 1 + LWB, "R3 move wb in overlap", last_wb - h2, LCV + 1 + LWB);
        chk(comp_log[0] == 1 && comp_log[1] == 2, "R9 in-order pair", comp_log[0] * 16 + comp_log[1], 18);

        // R9 longer in-order sequence
        clear_logs();
        for (int i = 0; i < 6; i++) send((i % 2 == 0) ? 0 : 3, 7, i, i + 4);
        idle(2 * L + 10);
        for (int i = 0; i < 6; i++)
            chk(comp_log[i] == i + 4, "R9 write-back order", comp_log[i], i + 4);

        // R7 read-after-write: store waits for the write-back
        clear_logs();
        send(0, 7, 3, 5); h1 = last_hs;
        send(2, 3, 0, 6); h2 = last_hs;
        idle(L + 6);
        chk(h2 == h1 + L + 1, "R7 dependent store accept", h2 - h1, L + 1);
        chk(last_st == h2 + LCV, "R7 dependent store done", last_st - h2, LCV);
        chk(comp_log[0] == 5 && comp_log[1] == 6, "R7 dependency order", comp_log[0] * 16 + comp_log[1], 86);

        // R7 write-after-write: load waits on busy destination
        clear_logs();
        send(0, 7, 4, 7); h1 = last_hs;
        send(1, 0, 4, 8); h2 = last_hs;
        idle(2 * L + 6);
        chk(h2 == h1 + L + 1, "R7 destination busy", h2 - h1, L + 1);

        // R9 independent store overtakes earlier arithmetic
        clear_logs();
        send(0, 7, 1, 9); h1 = last_hs;
        send(2, 5, 0, 10); h2 = last_hs;
        idle(L + 6);
        chk(h2 == h1 + LCV + 1, "R10 store overlap accept", h2 - h1, LCV + 1);
        chk(comp_log[0] == 10 && comp_log[1] == 9, "R9 store first", comp_log[0] * 16 + comp_log[1], 169);

        // R8 issue held through load conversion pass
        clear_logs();
        send(1, 0, 2, 11); h1 = last_hs;
        send(0, 7, 6, 12); h2 = last_hs;
        idle(2 * L + 6);
        chk(h2 == h1 + L + LCV + 1, "R8 accept after recirculation", h2 - h1, L + LCV + 1);
        chk(comp_log[0] == 11 && comp_log[1] == 12, "R8 load then arith", comp_log[0] * 16 + comp_log[1], 188);

        // R1 idle again: every register free, so an op is accepted at once
        clear_logs();
        @(negedge clk);
        chk(op_ready == 1'b1, "R1 idle ready", int'(op_ready), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule